// File: doc/BRIEF.md
# Single-Precision Rounding and Packing Stage with Run-Time Mode

This block is the last stage of a single-precision floating-point unit: 8 exponent bits and 24 significand bits, counting the hidden one. An upstream arithmetic datapath delivers a result that is not yet rounded. That result has a sign and a signed biased exponent wide enough to lie outside the normal range. It also has a normalised 24-bit significand followed by one guard bit and one sticky bit. Alongside it come flags for NaN, infinity, zero, invalid operation and signaling-NaN operand. The stage turns this into a packed 32-bit word. It also produces the overflow, underflow, inexact and invalid flags.

The rounding direction is not fixed when the block is built. A 5-bit one-hot selector is sampled with every operation and decoded by priority. When no selector bit is set, the result is the canonical quiet NaN. When the biased exponent is below 1, the stage shifts the significand right into the subnormal range before rounding. An increment that carries out of the significand renormalises it, and that carry can push the result into overflow. Each overflow is saturated according to the selected direction. All outputs are registered, so each result appears one clock after its inputs.

Top module: `rs_round_stage`

## Requirements
- R1: Selector bit 0 selects nearest ties-to-even, bit 1 nearest ties-away, bit 2 toward +infinity, bit 3 toward -infinity and bit 4 toward zero. When several bits are set, the lowest set bit decides.
- R2: A selector of 5'b00000 yields 32'h7FC00000 with overflow, underflow and inexact all clear, whatever the operand.
- R3: Ties-to-even increments the kept significand when the guard bit is set and either the sticky bit or the kept LSB is set. Ties-away increments whenever the guard bit is set. So an exact half with an even LSB is kept by ties-to-even and raised by ties-away, and an exact half with an odd LSB is raised by both.
- R4: Toward +infinity increments a positive magnitude when guard or sticky is set, and toward -infinity does the same for a negative magnitude. The opposite sign is truncated, and toward-zero always truncates.
- R5: An increment that carries out of the significand yields significand 1.000… and an exponent one higher. If that reaches exponent field 8'hFF, it is an overflow.
- R6: On overflow (final biased exponent of 255 or more), OF and NX are set. Both nearest modes give a signed infinity. Toward +infinity gives +inf for a positive result and -max (8'hFE exponent, all-ones fraction) for a negative one. Toward -infinity gives +max or -inf. Toward-zero gives the signed max and never an infinity.
- R7: An input biased exponent below 1 is shifted right by 1-exponent before rounding, and the bits shifted out feed guard and sticky. UF is set exactly when the rounded result is inexact and has exponent field 0. UF therefore always comes with NX and a subnormal or zero output, and a value that rounds up to the smallest normal raises no UF.
- R8: NX is set when any nonzero bit lies below the kept LSB after alignment, or on overflow.
- R9: A NaN input or the invalid flag gives 32'h7FC00000. An infinity or zero input gives the signed infinity or zero. In all these cases OF, UF and NX are clear. NV equals the invalid flag OR the signaling-operand flag, whatever the selector.
- R10: Outputs are registered with one clock of latency, and synchronous reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | 10 | Signed biased exponent (bias 127) |
| in_sig | input | 24 | Normalised significand, hidden bit at the top |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_nan | input | 1 | Result is NaN |
| in_inf | input | 1 | Result is infinity |
| in_zero | input | 1 | Result is zero |
| in_invalid | input | 1 | Upstream invalid operation |
| in_snan | input | 1 | An active operand was a signaling NaN |
| rnd_sel | input | 5 | One-hot rounding-direction selector |
| res_o | output | 32 | Packed single-precision result |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |
| nv_o | output | 1 | Invalid flag |

## Verification
The rounding carry and the overflow saturation can occur in the same cycle. An all-ones significand at biased exponent 254 or 255, with guard or sticky set, makes the increment push the exponent out of range. The bench judges the saturated word, and the resulting OF and NX, separately for each selector value and each sign. The subnormal shift and the carry also coincide: at exponent 0 an all-ones significand can round up to the smallest normal. That output must then show exponent field 1 and no UF. The expected values come from exact integer arithmetic on the operand, evaluated for all 32 selector codes.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // decoded rounding direction; RM_NONE when the selector is all zero
    typedef enum logic [2:0] {
        RM_EVEN = 3'd0,
        RM_AWAY = 3'd1,
        RM_UP   = 3'd2,
        RM_DOWN = 3'd3,
        RM_ZERO = 3'd4,
        RM_NONE = 3'd5
    } rmode_e;

    // class of the value being packed in this cycle
    typedef enum logic [2:0] {
        OC_NAN  = 3'd0,
        OC_INF  = 3'd1,
        OC_ZERO = 3'd2,
        OC_OVF  = 3'd3,
        OC_FIN  = 3'd4
    } oclass_e;

endpackage

// File: rtl/rs_mode_decode.sv
module rs_mode_decode
    import rs_pkg::*;
#(
    parameter int MODE_W = 5
) (
    input  logic [MODE_W-1:0] sel_i,
    output rmode_e            mode_o
);

    // lowest set bit wins (R1)
    always_comb begin
        mode_o = RM_NONE;
        for (int k = MODE_W - 1; k >= 0; k--) begin
            if (sel_i[k]) begin
                mode_o = rmode_e'(k);
            end
        end
    end

    always_comb begin
        if (sel_i == '0) begin
            AST_EMPTY_SEL: assert (mode_o == RM_NONE); // R2
        end else if (sel_i[0]) begin
            AST_BIT0_WINS: assert (mode_o == RM_EVEN); // R1
        end
    end

endmodule

// File: rtl/rs_denorm.sv
module rs_denorm #(
    parameter int SIG_W = 24,
    parameter int XW    = 10
) (
    input  logic signed [XW-1:0] exp_i,
    input  logic [SIG_W-1:0]     sig_i,
    input  logic                 g_i,
    input  logic                 s_i,
    output logic signed [XW-1:0] exp_o,
    output logic [SIG_W-1:0]     sig_o,
    output logic                 g_o,
    output logic                 s_o
);

    localparam int CAP = SIG_W + 1;
    localparam int SHW = $clog2(CAP + 1);
    localparam logic [SIG_W:0] ONES = '1;

    logic [SHW-1:0] amt;
    logic [SIG_W:0] ext, shifted, lost_mask;

    always_comb begin
        ext = {sig_i, g_i};
        if (exp_i > 0) begin
            amt = '0;
        end else if (int'(exp_i) < 1 - CAP) begin
            amt = SHW'(CAP);
        end else begin
            amt = SHW'(1 - int'(exp_i));
        end
        shifted   = ext >> amt;
        lost_mask = ~(ONES << amt);
        sig_o     = shifted[SIG_W:1];
        g_o       = shifted[0];
        s_o       = s_i | (|(ext & lost_mask));
        exp_o     = (exp_i > 0) ? exp_i : XW'(1);
    end

    always_comb begin
        if (exp_i < 1) begin
            AST_DENORM_HIDDEN: assert (!sig_o[SIG_W-1]); // R7
        end
    end

endmodule

// File: rtl/rs_round.sv
module rs_round
    import rs_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  rmode_e           mode_i,
    input  logic             sign_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             g_i,
    input  logic             s_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             carry_o,
    output logic             inc_o
);

    logic [SIG_W:0] sum;
    logic           lost;

    always_comb begin
        lost = g_i | s_i;
        unique case (mode_i)
            RM_EVEN: inc_o = g_i & (s_i | sig_i[0]);
            RM_AWAY: inc_o = g_i;
            RM_UP:   inc_o = lost & ~sign_i;
            RM_DOWN: inc_o = lost & sign_i;
            RM_ZERO: inc_o = 1'b0;
            RM_NONE: inc_o = 1'b0;
            default: inc_o = 1'b0;
        endcase
        sum     = {1'b0, sig_i} + (SIG_W + 1)'(inc_o);
        carry_o = sum[SIG_W];
        sig_o   = carry_o ? sum[SIG_W:1] : sum[SIG_W-1:0];
    end

    always_comb begin
        AST_INC_NEEDS_LOSS: assert (!inc_o || g_i || s_i); // R4
        AST_ZERO_TRUNCATES: assert (!(mode_i == RM_ZERO && inc_o)); // R4
    end

endmodule

// File: rtl/rs_round_stage.sv
module rs_round_stage
    import rs_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int SIG_W  = 24,
    parameter int MODE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_sign,
    input  logic signed [EXP_W+1:0]  in_exp,
    input  logic [SIG_W-1:0]         in_sig,
    input  logic                     in_guard,
    input  logic                     in_sticky,
    input  logic                     in_nan,
    input  logic                     in_inf,
    input  logic                     in_zero,
    input  logic                     in_invalid,
    input  logic                     in_snan,
    input  logic [MODE_W-1:0]        rnd_sel,
    output logic [EXP_W+SIG_W-1:0]   res_o,
    output logic                     of_o,
    output logic                     uf_o,
    output logic                     nx_o,
    output logic                     nv_o
);

    localparam int XW     = EXP_W + 2;
    localparam int FRAC_W = SIG_W - 1;
    localparam int RES_W  = EXP_W + SIG_W;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0]  EXP_ONES = '1;
    localparam logic [FRAC_W-1:0] FRAC_ONES = '1;
    localparam logic [RES_W-1:0]  QNAN =
        {1'b0, EXP_ONES, 1'b1, {(FRAC_W - 1){1'b0}}};

    rmode_e                mode;
    logic signed [XW-1:0]  exp_d;
    logic [SIG_W-1:0]      sig_d, sig_r;
    logic                  g_d, s_d, carry, inc;
    logic signed [XW:0]    exp_r;
    logic [EXP_W-1:0]      field;
    logic                  inexact, ovf, to_inf;
    oclass_e               cls;

    logic [RES_W-1:0]      res_n;
    logic                  of_n, uf_n, nx_n, nv_n;

    rs_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .sel_i  (rnd_sel),
        .mode_o (mode)
    );

    rs_denorm #(.SIG_W(SIG_W), .XW(XW)) u_dn (
        .exp_i (in_exp),
        .sig_i (in_sig),
        .g_i   (in_guard),
        .s_i   (in_sticky),
        .exp_o (exp_d),
        .sig_o (sig_d),
        .g_o   (g_d),
        .s_o   (s_d)
    );

    rs_round #(.SIG_W(SIG_W)) u_rnd (
        .mode_i  (mode),
        .sign_i  (in_sign),
        .sig_i   (sig_d),
        .g_i     (g_d),
        .s_i     (s_d),
        .sig_o   (sig_r),
        .carry_o (carry),
        .inc_o   (inc)
    );

    // exponent after renormalisation (R5) and overflow test (R6)
    always_comb begin
        exp_r   = {exp_d[XW-1], exp_d} + (XW + 1)'(carry);
        inexact = g_d | s_d;
        ovf     = sig_r[SIG_W-1] && (exp_r >= (XW + 1)'(EMAX));
        field   = sig_r[SIG_W-1] ? exp_r[EXP_W-1:0] : '0;
        unique case (mode)
            RM_EVEN, RM_AWAY: to_inf = 1'b1;
            RM_UP:            to_inf = ~in_sign;
            RM_DOWN:          to_inf = in_sign;
            default:          to_inf = 1'b0;
        endcase
    end

    // classify the value for this cycle (priority: NaN, inf, zero, finite)
    always_comb begin
        if (mode == RM_NONE || in_nan || in_invalid) begin
            cls = OC_NAN;
        end else if (in_inf) begin
            cls = OC_INF;
        end else if (in_zero) begin
            cls = OC_ZERO;
        end else if (ovf) begin
            cls = OC_OVF;
        end else begin
            cls = OC_FIN;
        end
    end

    // next outputs
    always_comb begin
        nv_n = in_invalid | in_snan;
        of_n = 1'b0;
        uf_n = 1'b0;
        nx_n = 1'b0;
        unique case (cls)
            OC_NAN:  res_n = QNAN;
            OC_INF:  res_n = {in_sign, EXP_ONES, {FRAC_W{1'b0}}};
            OC_ZERO: res_n = {in_sign, {(RES_W - 1){1'b0}}};
            OC_OVF: begin
                res_n = to_inf ? {in_sign, EXP_ONES, {FRAC_W{1'b0}}}
                               : {in_sign, EXP_ONES - EXP_W'(1), FRAC_ONES};
                of_n  = 1'b1;
                nx_n  = 1'b1;
            end
            OC_FIN: begin
                res_n = {in_sign, field, sig_r[FRAC_W-1:0]};
                nx_n  = inexact;
                uf_n  = inexact && (field == '0);
            end
            default: res_n = QNAN;
        endcase
    end

    // output register (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
            of_o  <= 1'b0;
            uf_o  <= 1'b0;
            nx_o  <= 1'b0;
            nv_o  <= 1'b0;
        end else begin
            res_o <= res_n;
            of_o  <= of_n;
            uf_o  <= uf_n;
            nx_o  <= nx_n;
            nv_o  <= nv_n;
        end
    end

    AST_UF_SUBNORMAL: assert property (@(posedge clk) disable iff (rst)
        uf_o |-> (nx_o && res_o[RES_W-2 -: EXP_W] == '0)); // R7

    AST_OF_SATURATES: assert property (@(posedge clk) disable iff (rst)
        of_o |-> (nx_o && res_o[RES_W-2 -: EXP_W] >= (EXP_ONES - EXP_W'(1)))); // R6

    AST_EMPTY_SEL_NAN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rnd_sel == '0))
            |-> (res_o == QNAN && !of_o && !uf_o && !nx_o)); // R2

    AST_RTZ_NO_INF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rnd_sel == MODE_W'(16)))
            |-> !(of_o && res_o[RES_W-2 -: EXP_W] == EXP_ONES)); // R6

    AST_NV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (nv_o == $past(in_invalid | in_snan))); // R9

endmodule

// File: tb/tb_rs_round_stage.sv
`timescale 1ns/1ps
module tb_rs_round_stage;

    localparam logic [31:0] QNAN = 32'h7FC00000;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_sign;
    logic signed [9:0]  in_exp;
    logic [23:0]        in_sig;
    logic               in_guard, in_sticky;
    logic               in_nan, in_inf, in_zero, in_invalid, in_snan;
    logic [4:0]         rnd_sel;
    logic [31:0]        res_o;
    logic               of_o, uf_o, nx_o, nv_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rs_round_stage dut (
        .clk(clk), .rst(rst), .in_sign(in_sign), .in_exp(in_exp),
        .in_sig(in_sig), .in_guard(in_guard), .in_sticky(in_sticky),
        .in_nan(in_nan), .in_inf(in_inf), .in_zero(in_zero),
        .in_invalid(in_invalid), .in_snan(in_snan), .rnd_sel(rnd_sel),
        .res_o(res_o), .of_o(of_o), .uf_o(uf_o), .nx_o(nx_o), .nv_o(nv_o)
    );

    // exact integer model of the rounded value
    function automatic void model(
        input  bit sg, input int e, input bit [23:0] m, input bit g, input bit s,
        input  bit [4:0] sel,
        output bit [31:0] r, output bit of, output bit uf, output bit nx,
        output string tag);
        int md, sh, low, ee, fld;
        logic [127:0] w, q, rem, half;
        bit up, inx;
        md = -1;
        for (int k = 0; k < 5; k++) if (sel[k] && md < 0) md = k;
        of = 0; uf = 0; nx = 0;
        if (md < 0) begin
            r = QNAN; tag = "R2"; return;
        end
        sh   = (e >= 1) ? 0 : 1 - e;
        if (sh > 40) sh = 40;
        w    = (128'(m) << 41) | (128'(g) << 40) | 128'(s);
        low  = 41 + sh;
        q    = w >> low;
        rem  = w & ((128'd1 << low) - 128'd1);
        half = 128'd1 << (low - 1);
        inx  = (rem != 0);
        case (md)
            0: up = (rem > half) || (rem == half && q[0]);
            1: up = (rem >= half);
            2: up = inx && !sg;
            3: up = inx && sg;
            default: up = 0;
        endcase
        q  = q + 128'(up);
        ee = (e >= 1) ? e : 1;
        if (q >= (128'd1 << 24)) begin
            q = q >> 1; ee = ee + 1;
        end
        fld = (q >= (128'd1 << 23)) ? ee : 0;
        if (fld >= 255) begin
            of = 1; nx = 1;
            if (md <= 1 || (md == 2 && !sg) || (md == 3 && sg))
                r = {sg, 8'hFF, 23'h0};
            else
                r = {sg, 8'hFE, 23'h7FFFFF};
            tag = "R6";
        end else begin
            r  = {sg, fld[7:0], q[22:0]};
            nx = inx;
            uf = inx && fld == 0;
            if (e < 1) tag = "R7";
            else if (fld != e) tag = "R5";
            else if ($countones(sel) > 1) tag = "R1";
            else if (md <= 1) tag = "R3";
            else tag = "R4";
        end
    endfunction

    task automatic check(input string tag, input bit [31:0] er, input bit eo,
                         input bit eu, input bit ex, input bit ev);
        n_vec++;
        if (res_o !== er) begin
            n_bad++;
            $display("FAIL %s result: got %h expected %h", tag, res_o, er);
        end
        if ({of_o, uf_o, nx_o} !== {eo, eu, ex}) begin
            n_bad++;
            $display("FAIL R8 flags (%s) OF/UF/NX: got %b%b%b expected %b%b%b",
                     tag, of_o, uf_o, nx_o, eo, eu, ex);
        end
        if (nv_o !== ev) begin
            n_bad++;
            $display("FAIL R9 NV: got %b expected %b", nv_o, ev);
        end
    endtask

    task automatic clear_in();
        in_sign = 0; in_exp = 10'sd127; in_sig = 24'h800000;
        in_guard = 0; in_sticky = 0; in_nan = 0; in_inf = 0;
        in_zero = 0; in_invalid = 0; in_snan = 0; rnd_sel = 5'd1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int exps[14] = '{1, 2, 127, 253, 254, 255, 300, 0, -1, -5, -22, -23, -24, -30};
        logic [23:0] bases[3] = '{24'hFFFFFE, 24'h800000, 24'hB6D5A4};
        bit [31:0] er;
        bit eo, eu, ex;
        string tag;

        clear_in();
        rnd_sel = 5'd0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs cleared while reset is held, even with a NaN-producing selector
        check("R10", 32'h0, 0, 0, 0, 0);
        rst = 1'b0;

        // finite operands across every selector code
        for (int sel = 0; sel < 32; sel++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int xi = 0; xi < 14; xi++) begin
                    for (int bi = 0; bi < 3; bi++) begin
                        for (int low = 0; low < 8; low++) begin
                            clear_in();
                            rnd_sel   = 5'(sel);
                            in_sign   = sg[0];
                            in_exp    = 10'(exps[xi]);
                            in_sig    = bases[bi] | 24'(low[2]);
                            in_guard  = low[1];
                            in_sticky = low[0];
                            model(sg[0], exps[xi], in_sig, low[1], low[0],
                                  5'(sel), er, eo, eu, ex, tag);
                            @(posedge clk);
                            @(negedge clk);
                            check(tag, er, eo, eu, ex, 0);
                        end
                    end
                end
            end
        end

        // special operands: R9 (R2 when the selector is empty)
        for (int sel = 0; sel < 32; sel++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int kind = 0; kind < 5; kind++) begin
                    clear_in();
                    rnd_sel = 5'(sel);
                    in_sign = sg[0];
                    in_guard = 1; in_sticky = 1;
                    case (kind)
                        0: in_nan = 1;
                        1: begin in_nan = 1; in_snan = 1; end
                        2: in_invalid = 1;
                        3: in_inf = 1;
                        default: in_zero = 1;
                    endcase
                    if (sel == 0 || kind <= 2) er = QNAN;
                    else if (kind == 3) er = {sg[0], 8'hFF, 23'h0};
                    else er = {sg[0], 31'h0};
                    @(posedge clk);
                    @(negedge clk);
                    check((sel == 0) ? "R2" : "R9", er, 0, 0, 0, kind == 1 || kind == 2);
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule